// File: doc/BRIEF.md
# PWM Compare Output Waveform Unit

This block forms one output channel of a 16-bit timer. Each cycle it takes the timer's count value, its count direction and its TOP and BOTTOM event flags, and compares the count with a compare value. From the result it drives one output pin. A 4-bit waveform-mode select picks one of three mode families: non-PWM, single-slope fast PWM or dual-slope phase-correct PWM. A 2-bit output-action field then chooses what a compare match, and in fast PWM a BOTTOM event, does to the pin.

The pin level is held in a two-state machine with the states `WAVE_LOW` and `WAVE_HIGH`. On each clock edge it takes one of four transitions: hold, set (to `WAVE_HIGH`), clear (to `WAVE_LOW`) or toggle. When the mode and field leave the channel disconnected, the pin follows a separate port-output input and the state machine holds its level. A force strobe makes an immediate compare match in non-PWM modes. The counter that produces the count and its flags lives outside this block. In the testbench it is modelled by directed stimulus.

Top module: `pwm_cmp_out_unit`

## Requirements
- R1: In reset the wave state is `WAVE_LOW`. After reset, with action field 00, `pin_out` equals `port_drv`. Every transition becomes visible on `pin_out` after the clock edge at which its event is present.
- R2: Waveform modes 0, 4 and 12 are non-PWM. Modes 5, 6, 7, 14 and 15 are fast PWM. Modes 1, 2, 3, 8, 9, 10 and 11 are phase-correct. Mode 13 is reserved and always leaves the pin disconnected.
- R3: Action field 00 disconnects the pin in every mode. `pin_out` then equals `port_drv`.
- R4: In non-PWM modes a compare match (`cnt_val == cmp_val`) does the following: field 01 toggles the wave state, field 10 clears it and field 11 sets it.
- R5: In non-PWM modes, `force_cmp` high for one cycle applies the same transition as a match. A strobe that coincides with a real match applies that transition only once.
- R6: In fast PWM and phase-correct modes, `force_cmp` has no effect on the wave state.
- R7: In fast PWM, field 10 clears on a match and sets at BOTTOM. Field 11 sets on a match and clears at BOTTOM. When a match and BOTTOM occur in the same cycle, the match wins. In field 10 the pin is high for exactly `cmp_val` cycles of each `top_val`+1 cycle period.
- R8: In fast PWM, field 01 toggles on a match only in mode 15. In the other fast PWM modes, field 01 disconnects the pin.
- R9: In fast PWM with field 1x and `cmp_val == top_val`, a compare match is ignored. Only the BOTTOM action occurs.
- R10: In phase-correct modes, field 10 clears on a match while counting up (`cnt_up`=1) and sets on a match while counting down. Field 11 does the reverse.
- R11: In phase-correct modes, field 01 toggles on a match only in mode 9. In other phase-correct modes, field 01 disconnects the pin.
- R12: While the pin is disconnected the wave state does not change. When the pin is connected again it shows the level held before it was disconnected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wave_mode | input | 4 | Waveform-mode select |
| out_action | input | 2 | Output-action field |
| cnt_val | input | 16 | Timer count |
| cnt_up | input | 1 | 1 while the timer counts up |
| cnt_at_top | input | 1 | Timer is at TOP this cycle |
| cnt_at_bottom | input | 1 | Timer is at BOTTOM this cycle |
| cmp_val | input | 16 | Compare value |
| top_val | input | 16 | Current TOP value of the timer |
| force_cmp | input | 1 | One-cycle force-compare strobe |
| port_drv | input | 1 | Port level used while the pin is disconnected |
| pin_out | output | 1 | Output pin |

## Verification
The embedded assertions check, on every cycle, the following:
- the toggle and hold transitions of the wave state machine;
- the BOTTOM set in fast PWM;
- that a match is ignored when the compare value equals TOP;
- the direction-dependent clear in phase-correct modes;
- that the force strobe has no effect in PWM modes.

The directed scenarios show the rest, because those behaviours only appear across mode changes or at the pin:
- the mode-family decoding, including the reserved mode;
- the pin following the port input while disconnected;
- retention of the level across a reconnect;
- a force strobe landing on a real match;
- the duty cycle over a full fast PWM period.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;

    typedef enum logic [1:0] {
        FAM_NONPWM = 2'd0,
        FAM_FAST   = 2'd1,
        FAM_PHASE  = 2'd2,
        FAM_RSVD   = 2'd3
    } wave_fam_t;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_TGL  = 2'd3
    } wave_act_t;

    typedef enum logic {
        WAVE_LOW  = 1'b0,
        WAVE_HIGH = 1'b1
    } wave_state_t;

    localparam int MODE_W   = 4;
    localparam int ACTION_W = 2;

endpackage

// File: rtl/pwm_mode_decode.sv
module pwm_mode_decode
    import pwm_cmp_pkg::*;
(
    input  logic [MODE_W-1:0] wave_mode,
    output wave_fam_t         family,
    output logic              toggle_ok
);

    localparam logic [MODE_W-1:0] FAST_TGL_MODE  = MODE_W'(15);
    localparam logic [MODE_W-1:0] PHASE_TGL_MODE = MODE_W'(9);

    always_comb begin
        unique case (wave_mode)
            4'd0, 4'd4, 4'd12:
                family = FAM_NONPWM;
            4'd5, 4'd6, 4'd7, 4'd14, 4'd15:
                family = FAM_FAST;
            4'd1, 4'd2, 4'd3, 4'd8, 4'd9, 4'd10, 4'd11:
                family = FAM_PHASE;
            default:
                family = FAM_RSVD;
        endcase
    end

    always_comb begin
        unique case (family)
            FAM_NONPWM: toggle_ok = 1'b1;
            FAM_FAST:   toggle_ok = (wave_mode == FAST_TGL_MODE);
            FAM_PHASE:  toggle_ok = (wave_mode == PHASE_TGL_MODE);
            FAM_RSVD:   toggle_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwm_event_resolve.sv
module pwm_event_resolve
    import pwm_cmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  wave_fam_t           family,
    input  logic                toggle_ok,
    input  logic [ACTION_W-1:0] out_action,
    input  logic [CNT_W-1:0]    cnt_val,
    input  logic                cnt_up,
    input  logic                cnt_at_bottom,
    input  logic [CNT_W-1:0]    cmp_val,
    input  logic [CNT_W-1:0]    top_val,
    input  logic                force_cmp,
    output logic                cmp_hit,
    output logic                connected,
    output wave_act_t           action
);

    logic      cmp_is_top;
    logic      fast_hit;
    wave_act_t raw_act;

    assign cmp_hit    = (cnt_val == cmp_val);
    assign cmp_is_top = (cmp_val == top_val);
    assign fast_hit   = cmp_hit && !cmp_is_top;

    always_comb begin
        connected = 1'b0;
        raw_act   = ACT_HOLD;
        unique case (family)
            FAM_NONPWM: begin
                connected = (out_action != 2'b00);
                if (cmp_hit || force_cmp) begin
                    unique case (out_action)
                        2'b01:   raw_act = ACT_TGL;
                        2'b10:   raw_act = ACT_CLR;
                        2'b11:   raw_act = ACT_SET;
                        default: raw_act = ACT_HOLD;
                    endcase
                end
            end
            FAM_FAST: begin
                unique case (out_action)
                    2'b01: begin
                        connected = toggle_ok;
                        if (cmp_hit) raw_act = ACT_TGL;
                    end
                    2'b10: begin
                        connected = 1'b1;
                        if (fast_hit)           raw_act = ACT_CLR;
                        else if (cnt_at_bottom) raw_act = ACT_SET;
                    end
                    2'b11: begin
                        connected = 1'b1;
                        if (fast_hit)           raw_act = ACT_SET;
                        else if (cnt_at_bottom) raw_act = ACT_CLR;
                    end
                    default: begin
                        connected = 1'b0;
                    end
                endcase
            end
            FAM_PHASE: begin
                unique case (out_action)
                    2'b01: begin
                        connected = toggle_ok;
                        if (cmp_hit) raw_act = ACT_TGL;
                    end
                    2'b10: begin
                        connected = 1'b1;
                        if (cmp_hit) raw_act = cnt_up ? ACT_CLR : ACT_SET;
                    end
                    2'b11: begin
                        connected = 1'b1;
                        if (cmp_hit) raw_act = cnt_up ? ACT_SET : ACT_CLR;
                    end
                    default: begin
                        connected = 1'b0;
                    end
                endcase
            end
            FAM_RSVD: begin
                connected = 1'b0;
            end
        endcase
    end

    assign action = connected ? raw_act : ACT_HOLD;

endmodule

// File: rtl/pwm_wave_fsm.sv
module pwm_wave_fsm
    import pwm_cmp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  wave_act_t action,
    output logic      wave_level
);

    wave_state_t state_q;
    wave_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WAVE_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (action)
            ACT_HOLD: state_d = state_q;
            ACT_SET:  state_d = WAVE_HIGH;
            ACT_CLR:  state_d = WAVE_LOW;
            ACT_TGL:  state_d = (state_q == WAVE_HIGH) ? WAVE_LOW : WAVE_HIGH;
        endcase
    end

    always_comb begin
        unique case (state_q)
            WAVE_LOW:  wave_level = 1'b0;
            WAVE_HIGH: wave_level = 1'b1;
        endcase
    end

    // R4
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (action == ACT_TGL) |=> (state_q != $past(state_q)));

    // R12
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (action == ACT_HOLD) |=> $stable(state_q));

endmodule

// File: rtl/pwm_cmp_out_unit.sv
module pwm_cmp_out_unit
    import pwm_cmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MODE_W-1:0]   wave_mode,
    input  logic [ACTION_W-1:0] out_action,
    input  logic [CNT_W-1:0]    cnt_val,
    input  logic                cnt_up,
    input  logic                cnt_at_top,
    input  logic                cnt_at_bottom,
    input  logic [CNT_W-1:0]    cmp_val,
    input  logic [CNT_W-1:0]    top_val,
    input  logic                force_cmp,
    input  logic                port_drv,
    output logic                pin_out
);

    wave_fam_t family;
    logic      toggle_ok;
    logic      cmp_hit;
    logic      connected;
    wave_act_t action;
    logic      wave_level;
    logic      top_seen;

    pwm_mode_decode u_decode (
        .wave_mode (wave_mode),
        .family    (family),
        .toggle_ok (toggle_ok)
    );

    pwm_event_resolve #(.CNT_W(CNT_W)) u_resolve (
        .family        (family),
        .toggle_ok     (toggle_ok),
        .out_action    (out_action),
        .cnt_val       (cnt_val),
        .cnt_up        (cnt_up),
        .cnt_at_bottom (cnt_at_bottom),
        .cmp_val       (cmp_val),
        .top_val       (top_val),
        .force_cmp     (force_cmp),
        .cmp_hit       (cmp_hit),
        .connected     (connected),
        .action        (action)
    );

    pwm_wave_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .action     (action),
        .wave_level (wave_level)
    );

    assign pin_out  = connected ? wave_level : port_drv;
    // The TOP flag causes no transition in this channel; it is carried only for the checks below.
    assign top_seen = cnt_at_top;

    // R6
    force_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (family != FAM_NONPWM && force_cmp && !cmp_hit && !cnt_at_bottom)
        |=> $stable(wave_level));

    // R7
    fast_bottom_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (family == FAM_FAST && out_action == 2'b10 && cnt_at_bottom && !cmp_hit)
        |=> wave_level);

    // R9
    top_match_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (family == FAM_FAST && out_action[1] && cmp_hit && (cmp_val == top_val)
         && !cnt_at_bottom) |=> $stable(wave_level));

    // R10
    phase_up_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (family == FAM_PHASE && out_action == 2'b10 && cmp_hit && cnt_up)
        |=> !wave_level);

    // R3
    top_flag_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (top_seen && out_action == 2'b00) |=> $stable(wave_level));

endmodule

// File: tb/pwm_cmp_out_unit_tb.sv
`timescale 1ns/100ps
module pwm_cmp_out_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  wave_mode;
    logic [1:0]  out_action;
    logic [15:0] cnt_val;
    logic        cnt_up;
    logic        cnt_at_top;
    logic        cnt_at_bottom;
    logic [15:0] cmp_val;
    logic [15:0] top_val;
    logic        force_cmp;
    logic        port_drv;
    logic        pin_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [15:0] PARK = 16'h7777;

    always #2.5 clk = ~clk;

    pwm_cmp_out_unit dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .wave_mode     (wave_mode),
        .out_action    (out_action),
        .cnt_val       (cnt_val),
        .cnt_up        (cnt_up),
        .cnt_at_top    (cnt_at_top),
        .cnt_at_bottom (cnt_at_bottom),
        .cmp_val       (cmp_val),
        .top_val       (top_val),
        .force_cmp     (force_cmp),
        .port_drv      (port_drv),
        .pin_out       (pin_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: pin_out=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Apply one cycle of counter events, then park the inputs and sample after the edge.
    task automatic cyc(input logic [15:0] c, input logic up, input logic tp,
                       input logic bt, input logic frc);
        cnt_val = c; cnt_up = up; cnt_at_top = tp; cnt_at_bottom = bt; force_cmp = frc;
        @(posedge clk); #1;
        cnt_val = PARK; cnt_at_top = 1'b0; cnt_at_bottom = 1'b0; force_cmp = 1'b0;
    endtask

    task automatic set_cfg(input logic [3:0] m, input logic [1:0] a);
        wave_mode = m; out_action = a; #0.1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; wave_mode = 4'd0; out_action = 2'b00; cnt_val = PARK;
        cnt_up = 1'b1; cnt_at_top = 1'b0; cnt_at_bottom = 1'b0;
        cmp_val = 16'd100; top_val = 16'd200; force_cmp = 1'b0; port_drv = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 field00 follows port", pin_out, 1'b1);
        port_drv = 1'b0; #0.1;
        check("R3 field00 follows port low", pin_out, 1'b0);
        set_cfg(4'd0, 2'b11);
        check("R1 reset wave low", pin_out, 1'b0);
    endtask

    task automatic t_nonpwm;
        set_cfg(4'd4, 2'b01);
        cyc(16'd100, 1'b1, 1'b0, 1'b0, 1'b0); check("R4 toggle up", pin_out, 1'b1);
        cyc(16'd100, 1'b1, 1'b0, 1'b0, 1'b0); check("R4 toggle down", pin_out, 1'b0);
        set_cfg(4'd12, 2'b11);
        cyc(16'd50, 1'b1, 1'b0, 1'b0, 1'b0);  check("R4 no match holds", pin_out, 1'b0);
        cyc(16'd100, 1'b1, 1'b0, 1'b0, 1'b0); check("R4 set on match", pin_out, 1'b1);
        set_cfg(4'd0, 2'b10);
        cyc(16'd100, 1'b1, 1'b0, 1'b0, 1'b0); check("R4 clear on match", pin_out, 1'b0);
    endtask

    task automatic t_force;
        set_cfg(4'd0, 2'b01);
        cyc(16'd50, 1'b1, 1'b0, 1'b0, 1'b1);  check("R5 force toggles", pin_out, 1'b1);
        cyc(16'd100, 1'b1, 1'b0, 1'b0, 1'b1); check("R5 force+match toggles once", pin_out, 1'b0);
        set_cfg(4'd0, 2'b11);
        cyc(16'd50, 1'b1, 1'b0, 1'b0, 1'b1);  check("R5 force sets", pin_out, 1'b1);
        set_cfg(4'd14, 2'b10);
        cyc(16'd50, 1'b1, 1'b0, 1'b0, 1'b1);  check("R6 force ignored fast", pin_out, 1'b1);
        set_cfg(4'd1, 2'b11);
        cyc(16'd50, 1'b0, 1'b0, 1'b0, 1'b1);  check("R6 force ignored phase", pin_out, 1'b1);
    endtask

    task automatic t_fast;
        cmp_val = 16'd100; top_val = 16'd200;
        set_cfg(4'd14, 2'b10);
        cyc(16'd100, 1'b1, 1'b0, 1'b0, 1'b0); check("R7 noninv clear on match", pin_out, 1'b0);
        cyc(16'd0, 1'b1, 1'b0, 1'b1, 1'b0);   check("R7 noninv set at bottom", pin_out, 1'b1);
        set_cfg(4'd5, 2'b11);
        cyc(16'd0, 1'b1, 1'b0, 1'b1, 1'b0);   check("R7 inv clear at bottom", pin_out, 1'b0);
        cyc(16'd100, 1'b1, 1'b0, 1'b0, 1'b0); check("R7 inv set on match", pin_out, 1'b1);
        cmp_val = 16'd0; set_cfg(4'd6, 2'b10);
        cyc(16'd0, 1'b1, 1'b0, 1'b1, 1'b0);   check("R7 match wins over bottom", pin_out, 1'b0);
        cmp_val = 16'd200; set_cfg(4'd14, 2'b10);
        cyc(16'd0, 1'b1, 1'b0, 1'b1, 1'b0);   check("R9 bottom sets", pin_out, 1'b1);
        cyc(16'd200, 1'b1, 1'b1, 1'b0, 1'b0); check("R9 match at TOP ignored", pin_out, 1'b1);
        cmp_val = 16'd100;
        set_cfg(4'd15, 2'b01);
        cyc(16'd100, 1'b1, 1'b0, 1'b0, 1'b0); check("R8 mode15 toggles", pin_out, 1'b0);
        set_cfg(4'd14, 2'b01);
        port_drv = 1'b1; #0.1;
        check("R8 mode14 field01 disconnected", pin_out, 1'b1);
        cyc(16'd100, 1'b1, 1'b0, 1'b0, 1'b0);
        port_drv = 1'b0; #0.1;
        check("R12 disconnected follows port", pin_out, 1'b0);
        set_cfg(4'd14, 2'b10);
        check("R12 level kept across disconnect", pin_out, 1'b0);
    endtask

    task automatic t_fast_period;
        int highs = 0;
        cmp_val = 16'd3; top_val = 16'd9;
        set_cfg(4'd14, 2'b10);
        for (int k = 0; k <= 9; k++) cyc(16'(k), 1'b1, k == 9, k == 0, 1'b0);
        for (int k = 0; k <= 9; k++) begin
            cyc(16'(k), 1'b1, k == 9, k == 0, 1'b0);
            if (pin_out) highs++;
        end
        n_chk++;
        if (highs != 3) begin
            n_fail++;
            $display("FAIL R7 duty: high cycles=%0d expected=%0d", highs, 3);
        end
    endtask

    task automatic t_phase;
        cmp_val = 16'd100; top_val = 16'd200;
        set_cfg(4'd1, 2'b10);
        cyc(16'd100, 1'b1, 1'b0, 1'b0, 1'b0); check("R10 f10 up clears", pin_out, 1'b0);
        cyc(16'd100, 1'b0, 1'b0, 1'b0, 1'b0); check("R10 f10 down sets", pin_out, 1'b1);
        set_cfg(4'd10, 2'b11);
        cyc(16'd100, 1'b0, 1'b0, 1'b0, 1'b0); check("R10 f11 down clears", pin_out, 1'b0);
        cyc(16'd100, 1'b1, 1'b0, 1'b0, 1'b0); check("R10 f11 up sets", pin_out, 1'b1);
        set_cfg(4'd9, 2'b01);
        cyc(16'd100, 1'b0, 1'b0, 1'b0, 1'b0); check("R11 mode9 toggles", pin_out, 1'b0);
        set_cfg(4'd2, 2'b01);
        port_drv = 1'b1; #0.1;
        check("R11 mode2 field01 disconnected", pin_out, 1'b1);
        set_cfg(4'd13, 2'b11);
        port_drv = 1'b0; #0.1;
        check("R2 mode13 reserved disconnected", pin_out, 1'b0);
        cyc(16'd100, 1'b1, 1'b0, 1'b0, 1'b1);
        set_cfg(4'd8, 2'b10);
        check("R2 mode8 phase family, level held", pin_out, 1'b0);
        cyc(16'd100, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R2 mode8 phase down sets", pin_out, 1'b1);
    endtask

    initial begin
        t_reset();
        t_nonpwm();
        t_force();
        t_fast();
        t_fast_period();
        t_phase();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run incomplete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule